// File: doc/BRIEF.md
# Serial CRC-16 Frame Check Generator and Checker

This block computes a 16-bit cyclic redundancy check over a serial bit stream, one bit per accepted cycle, most significant message bit first. In generate mode it forwards each message bit to its output one cycle after it is accepted and, as soon as the final message bit has gone by, follows it with the 16 remainder bits, so the output stream is the message with its check field appended. In check mode the same shift register divides a received frame that already carries its check field; at the end of the frame the block reports whether the remainder came out zero.

A frame opens with a one-cycle start pulse that clears the register and latches the mode. Bits are then offered with a valid strobe; the end marker rides on the valid strobe of the last bit. While the check field is being shifted out the block is busy and takes no input of any kind, so the user must hold off the next frame until busy drops.

Top module: `crc16_fcs_gen`

## Requirements
- R1: After reset, out_vld_o, out_bit_o, busy_o, chk_done_o and crc_ok_o are all low.
- R2: The check field equals the modulo-2 remainder of the message times x^16 divided by x^16 + x^15 + x^2 + 1 (tap mask 0x8005), with the register cleared to zero at each accepted start pulse; message and check field both travel most significant bit first.
- R3: In generate mode each accepted message bit appears on out_bit_o with out_vld_o high in the following cycle.
- R4: In generate mode the 16 check bits follow the last message bit on consecutive cycles, highest-order bit first, so out_vld_o is high for exactly message length plus 16 cycles per frame.
- R5: busy_o rises in the cycle after the last message bit is accepted and stays high for exactly 16 cycles; while it is high, start pulses, valid bits and end markers are ignored.
- R6: In check mode out_vld_o stays low, chk_done_o pulses for one cycle in the cycle after the end-marked bit, and crc_ok_o is high from that cycle on only if the remainder over the whole frame is zero; crc_ok_o holds until the next accepted start pulse.
- R7: Bits with bit_vld_i low, end markers without bit_vld_i, and valid bits offered outside an open frame are not consumed and produce no output.
- R8: A start pulse while a frame is open abandons it: the check field covers only the bits after the latest start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_mode_i | input | 1 | Mode latched with the start pulse: 0 generate, 1 check |
| sof_i | input | 1 | Start-of-frame pulse; clears the register |
| bit_vld_i | input | 1 | bit_i holds a frame bit this cycle |
| bit_i | input | 1 | Serial frame bit |
| eof_i | input | 1 | Marks the valid bit as the last of the frame |
| out_vld_o | output | 1 | out_bit_o carries a transmitted bit |
| out_bit_o | output | 1 | Outgoing message or check bit |
| busy_o | output | 1 | Check field being shifted out; inputs ignored |
| chk_done_o | output | 1 | One-cycle pulse when a check-mode frame ends |
| crc_ok_o | output | 1 | Zero remainder seen at the end of the last checked frame |

## Verification
The bound checker watches, on every cycle, that each busy window lasts exactly 16 cycles, that the output stays valid through and one cycle past every busy window, that a forwarded message bit matches the input bit of the cycle before, that the check-done pulse is a single cycle that follows an end-marked valid bit, and that the pass flag changes only at a start pulse or a check-done. The numeric value of the check field, the zero-remainder verdict on clean and corrupted frames, the dropping of input during busy and outside frames, and the restart on a second start pulse can only be shown by the bench scenarios, which compare the output stream against a bitwise long-division model.

// File: rtl/crc16_fcs_pkg.sv
package crc16_fcs_pkg;

   // Frame phase of the serial engine
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,   // no frame open
      PH_MSG  = 2'd1,   // taking message bits
      PH_FCS  = 2'd2    // shifting out the remainder
   } phase_e;

endpackage

// File: rtl/crc16_lfsr.sv
// One division step of the serial CRC register.
// Feeding din_i = cur_i[W-1] cancels the feedback and turns the step
// into a plain left shift, which is how the remainder is drained.
module crc16_lfsr #(
   parameter int unsigned    W    = 16,
   parameter logic [W-1:0]   POLY = 16'h8005
) (
   input  logic [W-1:0] cur_i,
   input  logic         din_i,
   output logic [W-1:0] nxt_o
);

   logic fb;
   assign fb = cur_i[W-1] ^ din_i;

   generate
      for (genvar k = 0; k < W; k++) begin : g_stage
         if (k == 0) begin : g_first
            assign nxt_o[0] = POLY[0] & fb;
         end else begin : g_rest
            assign nxt_o[k] = cur_i[k-1] ^ (POLY[k] & fb);
         end
      end
   endgenerate

endmodule

// File: rtl/crc16_ctrl.sv
// Frame sequencer: opens frames, qualifies bits, times the drain.
module crc16_ctrl
   import crc16_fcs_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   sof_i,
   input  logic   chk_mode_i,
   input  logic   bit_vld_i,
   input  logic   eof_i,
   output phase_e phase_o,
   output logic   mode_o,
   output logic   open_o,
   output logic   take_o,
   output logic   fin_o
);

   localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   phase_e        phase_q, phase_d;
   logic          mode_q;
   logic [CW-1:0] cnt_q;
   logic          busy;

   assign busy   = (phase_q == PH_FCS);
   assign open_o = sof_i && !busy;
   assign take_o = !sof_i && bit_vld_i && (phase_q == PH_MSG);
   assign fin_o  = take_o && eof_i;

   always_comb begin
      phase_d = phase_q;
      if (open_o) begin
         phase_d = PH_MSG;
      end else if (fin_o) begin
         phase_d = mode_q ? PH_IDLE : PH_FCS;
      end else if (busy && (cnt_q == LAST)) begin
         phase_d = PH_IDLE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         mode_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (open_o) begin
            mode_q <= chk_mode_i;
         end
         if (fin_o) begin
            cnt_q <= '0;
         end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase_o = phase_q;
   assign mode_o  = mode_q;

endmodule

// File: rtl/crc16_fcs_gen.sv
// Serial CRC generator with systematic append and zero-remainder check.
module crc16_fcs_gen
   import crc16_fcs_pkg::*;
#(
   parameter int unsigned          WIDTH = 16,
   parameter logic [WIDTH-1:0]     POLY  = 16'h8005
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic chk_mode_i,
   input  logic sof_i,
   input  logic bit_vld_i,
   input  logic bit_i,
   input  logic eof_i,
   output logic out_vld_o,
   output logic out_bit_o,
   output logic busy_o,
   output logic chk_done_o,
   output logic crc_ok_o
);

   // Elaboration-time parameter checks
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("crc16_fcs_gen: WIDTH must be at least 2");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("crc16_fcs_gen: generator must have a constant term");
      end
   endgenerate

   phase_e           phase;
   logic             mode, open_frame, take, fin, busy;
   logic [WIDTH-1:0] crc_q, crc_nxt;
   logic             step_din;
   logic             out_vld_q, out_bit_q, done_q, ok_q;

   crc16_ctrl #(.W(WIDTH)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sof_i      (sof_i),
      .chk_mode_i (chk_mode_i),
      .bit_vld_i  (bit_vld_i),
      .eof_i      (eof_i),
      .phase_o    (phase),
      .mode_o     (mode),
      .open_o     (open_frame),
      .take_o     (take),
      .fin_o      (fin)
   );

   assign busy     = (phase == PH_FCS);
   assign step_din = busy ? crc_q[WIDTH-1] : bit_i;

   crc16_lfsr #(.W(WIDTH), .POLY(POLY)) u_lfsr (
      .cur_i (crc_q),
      .din_i (step_din),
      .nxt_o (crc_nxt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         crc_q     <= '0;
         out_vld_q <= 1'b0;
         out_bit_q <= 1'b0;
         done_q    <= 1'b0;
         ok_q      <= 1'b0;
      end else begin
         if (open_frame) begin
            crc_q <= '0;
         end else if (take || busy) begin
            crc_q <= crc_nxt;
         end

         out_vld_q <= busy || (take && !mode);
         if (busy) begin
            out_bit_q <= crc_q[WIDTH-1];
         end else if (take && !mode) begin
            out_bit_q <= bit_i;
         end else begin
            out_bit_q <= 1'b0;
         end

         done_q <= fin && mode;
         if (open_frame) begin
            ok_q <= 1'b0;
         end else if (fin && mode) begin
            ok_q <= (crc_nxt == '0);
         end
      end
   end

   assign out_vld_o  = out_vld_q;
   assign out_bit_o  = out_bit_q;
   assign busy_o     = busy;
   assign chk_done_o = done_q;
   assign crc_ok_o   = ok_q;

endmodule

// File: rtl/crc16_fcs_gen_chk.sv
// Protocol checker bound to the CRC engine.
module crc16_fcs_gen_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic clk_i,
   input logic rst_ni,
   input logic sof_i,
   input logic bit_vld_i,
   input logic bit_i,
   input logic eof_i,
   input logic out_vld_o,
   input logic out_bit_o,
   input logic busy_o,
   input logic chk_done_o,
   input logic crc_ok_o
);

   localparam int unsigned RW = $clog2(WIDTH + 2);

   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else begin
         run_q <= busy_o ? run_q + 1'b1 : '0;
      end
   end

   // R5
   busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (run_q == RW'(WIDTH)));

   // R5
   busy_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (run_q < RW'(WIDTH)));

   // R4
   drain_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> out_vld_o);

   // R4
   last_msg_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> out_vld_o);

   // R3
   forward_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && !busy_o && !$past(busy_o))
         |-> ($past(bit_vld_i) && (out_bit_o == $past(bit_i))));

   // R6
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_done_o |=> !chk_done_o);

   // R6
   done_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_done_o |-> ($past(eof_i) && $past(bit_vld_i) && !busy_o && !out_vld_o));

   // R6
   ok_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!chk_done_o && !$past(sof_i)) |-> $stable(crc_ok_o));

endmodule

bind crc16_fcs_gen crc16_fcs_gen_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .sof_i      (sof_i),
   .bit_vld_i  (bit_vld_i),
   .bit_i      (bit_i),
   .eof_i      (eof_i),
   .out_vld_o  (out_vld_o),
   .out_bit_o  (out_bit_o),
   .busy_o     (busy_o),
   .chk_done_o (chk_done_o),
   .crc_ok_o   (crc_ok_o)
);

// File: tb/crc16_fcs_gen_test.sv
module crc16_fcs_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int MAXB = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chk_mode = 1'b0, sof = 1'b0, bit_vld = 1'b0, din = 1'b0, eof = 1'b0;
   logic out_vld, out_bit, busy, chk_done, crc_ok;

   int checks = 0;
   int failures = 0;

   logic msg [0:255];
   logic cap [0:MAXB-1];
   int   cap_n = 0;
   int   busy_n = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc16_fcs_gen uut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .chk_mode_i (chk_mode),
      .sof_i      (sof),
      .bit_vld_i  (bit_vld),
      .bit_i      (din),
      .eof_i      (eof),
      .out_vld_o  (out_vld),
      .out_bit_o  (out_bit),
      .busy_o     (busy),
      .chk_done_o (chk_done),
      .crc_ok_o   (crc_ok)
   );

   // Output monitor, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_vld && cap_n < MAXB) begin
            cap[cap_n] = out_bit;
            cap_n = cap_n + 1;
         end
         if (busy) busy_n = busy_n + 1;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Long-division model of the check field over msg[0:len-1]
   function automatic logic [15:0] ref_crc(input int len);
      logic [15:0] r = 16'h0;
      for (int i = 0; i < len; i++) begin
         logic fb = r[15] ^ msg[i];
         r = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h8005;
      end
      return r;
   endfunction

   task automatic load_bytes(input int nbytes, input logic [7:0] seed, input logic [7:0] step);
      for (int b = 0; b < nbytes; b++) begin
         logic [7:0] v = seed + 8'(b) * step;
         for (int k = 0; k < 8; k++) msg[b*8+k] = v[7-k];
      end
   endtask

   // Opens a frame and sends len bits; gap_every>0 inserts idle cycles
   task automatic drive_frame(input logic mode, input int len, input int gap_every);
      @(negedge clk); sof = 1'b1; chk_mode = mode; bit_vld = 1'b0; eof = 1'b0;
      @(negedge clk); sof = 1'b0;
      for (int i = 0; i < len; i++) begin
         if (gap_every > 0 && (i % gap_every) == 1) begin
            bit_vld = 1'b0; din = ~msg[i]; eof = 1'b1;
            @(negedge clk);
         end
         bit_vld = 1'b1; din = msg[i]; eof = (i == len - 1);
         @(negedge clk);
      end
      bit_vld = 1'b0; eof = 1'b0; din = 1'b0;
   endtask

   task automatic check_stream(input string req, input int base, input int len,
                               input logic [15:0] fcs);
      int bad = 0;
      chk(req, "output bit count", 32'(cap_n - base), 32'(len + 16));
      for (int i = 0; i < len; i++) if (cap[base+i] !== msg[i]) bad++;
      chk("R3", "mismatched message bits", 32'(bad), 32'd0);
      begin
         logic [15:0] got;
         for (int k = 0; k < 16; k++) got[15-k] = cap[base+len+k];
         chk("R2", "appended check field", {16'h0, got}, {16'h0, fcs});
      end
   endtask

   task automatic t_reset();
      chk("R1", "out_vld after reset", {31'h0, out_vld}, 32'd0);
      chk("R1", "busy after reset", {31'h0, busy}, 32'd0);
      chk("R1", "chk_done/crc_ok/out_bit after reset",
          {29'h0, chk_done, crc_ok, out_bit}, 32'd0);
   endtask

   task automatic t_known_vector();
      int base = cap_n, bb = busy_n;
      load_bytes(9, 8'h31, 8'h01);
      chk("R2", "model on digit string", {16'h0, ref_crc(72)}, 32'h0000fee8);
      drive_frame(1'b0, 72, 0);
      chk("R5", "busy in cycle after last bit", {31'h0, busy}, 32'd1);
      repeat (20) @(negedge clk);
      check_stream("R4", base, 72, 16'hfee8);
      chk("R5", "busy cycle count", 32'(busy_n - bb), 32'd16);
   endtask

   task automatic t_single_bit();
      int base = cap_n;
      msg[0] = 1'b1;
      drive_frame(1'b0, 1, 0);
      repeat (20) @(negedge clk);
      check_stream("R4", base, 1, 16'h8005);
   endtask

   task automatic t_zero_msg();
      int base = cap_n;
      for (int i = 0; i < 24; i++) msg[i] = 1'b0;
      drive_frame(1'b0, 24, 0);
      repeat (20) @(negedge clk);
      check_stream("R2", base, 24, 16'h0000);
   endtask

   task automatic t_gaps_and_stray();
      int base;
      logic [15:0] e;
      load_bytes(5, 8'ha7, 8'h3d);
      e = ref_crc(40);
      base = cap_n;
      drive_frame(1'b0, 40, 3);
      repeat (20) @(negedge clk);
      check_stream("R7", base, 40, e);
      // valid bits with no open frame
      base = cap_n;
      for (int i = 0; i < 6; i++) begin
         bit_vld = 1'b1; din = i[0]; eof = (i == 5);
         @(negedge clk);
      end
      bit_vld = 1'b0; eof = 1'b0;
      repeat (4) @(negedge clk);
      chk("R7", "outputs from out-of-frame bits", 32'(cap_n - base), 32'd0);
   endtask

   task automatic t_busy_ignore();
      int base = cap_n, bb = busy_n;
      logic [15:0] e;
      load_bytes(3, 8'h5c, 8'h91);
      e = ref_crc(24);
      drive_frame(1'b0, 24, 0);
      for (int i = 0; i < 12; i++) begin
         sof = i[0]; chk_mode = 1'b1; bit_vld = 1'b1; din = i[1]; eof = 1'b1;
         @(negedge clk);
      end
      sof = 1'b0; chk_mode = 1'b0; bit_vld = 1'b0; eof = 1'b0;
      repeat (20) @(negedge clk);
      check_stream("R5", base, 24, e);
      chk("R5", "busy length with input during drain", 32'(busy_n - bb), 32'd16);
   endtask

   task automatic t_restart();
      int base;
      logic [15:0] e;
      load_bytes(4, 8'h12, 8'h47);
      e = ref_crc(32);
      base = cap_n;
      @(negedge clk); sof = 1'b1; chk_mode = 1'b0;
      @(negedge clk); sof = 1'b0;
      for (int i = 0; i < 9; i++) begin
         bit_vld = 1'b1; din = 1'b1; @(negedge clk);
      end
      bit_vld = 1'b0;
      drive_frame(1'b0, 32, 0);
      repeat (20) @(negedge clk);
      chk("R8", "output count incl abandoned bits", 32'(cap_n - base), 32'(9 + 32 + 16));
      begin
         logic [15:0] got;
         for (int k = 0; k < 16; k++) got[15-k] = cap[base+9+32+k];
         chk("R8", "check field after restart", {16'h0, got}, {16'h0, e});
      end
   endtask

   task automatic t_check_mode();
      int base = cap_n;
      logic [15:0] e;
      load_bytes(6, 8'h0f, 8'h6b);
      e = ref_crc(48);
      for (int k = 0; k < 16; k++) msg[48+k] = e[15-k];
      drive_frame(1'b1, 64, 0);
      chk("R6", "chk_done one cycle after eof", {31'h0, chk_done}, 32'd1);
      chk("R6", "crc_ok on clean frame", {31'h0, crc_ok}, 32'd1);
      @(negedge clk);
      chk("R6", "chk_done single pulse", {31'h0, chk_done}, 32'd0);
      chk("R6", "crc_ok held", {31'h0, crc_ok}, 32'd1);
      chk("R6", "no output in check mode", 32'(cap_n - base), 32'd0);
      msg[5] = ~msg[5];
      drive_frame(1'b1, 64, 2);
      chk("R6", "chk_done on corrupted frame", {31'h0, chk_done}, 32'd1);
      chk("R6", "crc_ok on corrupted frame", {31'h0, crc_ok}, 32'd0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_known_vector();
      t_single_bit();
      t_zero_msg();
      t_gaps_and_stray();
      t_busy_ignore();
      t_restart();
      t_check_mode();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule